// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block fronts a one-time-programmable fuse array of 8 banks, each holding 256 byte-wide words. Software reaches it over a simple 32-bit register bus with one-cycle write and read strobes and word addressing. Through that bus it sets a target bank, word and bit, arms a key, and starts either a program cycle that burns one fuse bit or a sense cycle that reads a whole fuse word into a data register. While a cycle runs, a busy flag stays up. The outcome is left in sticky status and error bits, and these also feed one combined interrupt line through per-bit enables.

The upper half of the address space gives a shadow view of every fuse word. Reading a shadow location returns the word's override value if one has been written, and otherwise the fused contents. Writing a shadow location stores an override value. Banks can be marked read-, write- or override-protected at build time. An access that breaks a protection is refused and flagged in the error register. The fuse storage is a behavioural model that reads as all zeros after reset.

Top module: `efuse_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The target is taken from the upper-address register (offset 5) and the lower-address register (offset 6). The bank is upper bits 5:3. The word index is upper bits 2:0 followed by lower bits 7:3. The bit number is lower bits 2:0. The shadow location of bank b, word w is address 0x800 + b*256 + w.
- R3: Writing the control register (offset 4) with bit 0 set starts a program cycle. If the key register (offset 8) holds 0xAA, the cycle burns exactly the addressed fuse bit and sets program-done, which is status (offset 0) bit 1.
- R4: A program start with any key other than 0xAA does not go busy and does not change the fuse array. It sets write-protect error, which is error (offset 1) bit 6, and leaves program-done clear.
- R5: A program start aimed at a write-protected bank (bank 6 by default) is refused in the same way as R4 and sets error bit 6.
- R6: An accepted cycle holds busy (status bit 7) high for exactly CYCLE_CLKS clocks. During the cycle, control bit 0 (program) or bit 3 (sense) reads back as 1, and it reads 0 once the cycle ends.
- R7: A control write with bit 3 set and bit 0 clear starts a sense cycle. On completion the sense-data register (offset 7) holds the fused word, without any override, and sense-done (status bit 0) is set.
- R8: A sense start aimed at a read-protected bank (bank 7 by default) does not go busy. It sets sense error (error bit 2), leaves sense-done clear and leaves sense-data unchanged.
- R9: A shadow read returns the last override written to that word, or the fused word if no override has been written. Burning a fuse bit changes what a shadow read returns for a word that has no override.
- R10: A shadow write to an override-protected bank (bank 5 by default) stores nothing and sets override-protect error (error bit 5).
- R11: A shadow read in a read-protected bank returns 0 and sets read-protect error (error bit 4).
- R12: Status bits 1:0 and error bits 7:1 are sticky and are cleared by writing 1 to them. Writing 1 to status bit 7 has no effect, and writing 0 clears nothing.
- R13: `irq` is high exactly when some status bit is set whose enable bit is set in the status-mask register (offset 2, bits 1:0), or some error bit is set whose enable bit is set in the error-mask register (offset 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_addr | input | 12 | Word address; bit 11 selects the shadow region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address, valid in the same cycle |
| irq | output | 1 | Combined masked status and error interrupt |

## Verification
Program cycles are driven at random banks, words and bits, with the key both present and absent. Each result is cross-checked by a sense cycle and by a shadow read, so that a wrong address decode shows up as a mismatched word or bit rather than as a missing burn. Random shadow overrides land among burned words, which shows whether sensing and shadow reads keep fused contents and overrides apart. Directed starts against each protected bank, together with write-1-to-clear patterns that set the wrong bits, separate the different refusal paths and show whether the sticky bits are held. The busy time is measured by polling the status register in every cycle, which pins the cycle length exactly.

// File: rtl/efuse_pkg.sv
package efuse_pkg;

    localparam int BANK_W    = 3;
    localparam int WORD_W    = 8;
    localparam int BIT_W     = 3;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = BANK_W + WORD_W;
    localparam int NUM_WORDS = 1 << IDX_W;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int REG_AW    = IDX_W + 1;

    localparam logic [7:0] PROG_KEY = 8'hAA;

    // register word offsets
    localparam int RA_STAT  = 0;
    localparam int RA_ERR   = 1;
    localparam int RA_STATM = 2;
    localparam int RA_EMASK = 3;
    localparam int RA_CTRL  = 4;
    localparam int RA_AHI   = 5;
    localparam int RA_ALO   = 6;
    localparam int RA_SDATA = 7;
    localparam int RA_KEY   = 8;

    // status bits
    localparam int ST_BUSY = 7;
    localparam int ST_PRGD = 1;
    localparam int ST_SNSD = 0;

    // error bits
    localparam int ER_PROG  = 7;
    localparam int ER_WPROT = 6;
    localparam int ER_OPROT = 5;
    localparam int ER_RPROT = 4;
    localparam int ER_LOCK  = 3;
    localparam int ER_SENSE = 2;
    localparam int ER_PAR   = 1;
    localparam logic [7:0] ER_IMPL = 8'hFE;

    // control bits
    localparam int FC_PRG = 0;
    localparam int FC_SNS = 3;
    localparam logic [7:0] FC_CFG_MASK = 8'hF6;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_SENSE = 2'd2
    } op_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [WORD_W-1:0] word;
        logic [BIT_W-1:0]  bitn;
    } fuse_loc_t;

    function automatic fuse_loc_t decode_loc(input logic [7:0] hi, input logic [7:0] lo);
        fuse_loc_t l;
        l.bank = hi[5:3];
        l.word = {hi[2:0], lo[7:3]};
        l.bitn = lo[2:0];
        return l;
    endfunction

    function automatic logic [IDX_W-1:0] loc_index(input fuse_loc_t l);
        return {l.bank, l.word};
    endfunction

endpackage

// File: rtl/efuse_array.sv
module efuse_array
    import efuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              burn,
    input  logic [IDX_W-1:0]  burn_idx,
    input  logic [BIT_W-1:0]  burn_bit,
    input  logic [IDX_W-1:0]  sense_idx,
    output logic [DATA_W-1:0] sense_word,
    input  logic [IDX_W-1:0]  sh_idx,
    input  logic              sh_wr,
    input  logic [DATA_W-1:0] sh_wdata,
    output logic [DATA_W-1:0] sh_rdata
);

    logic [DATA_W-1:0]    fuse_q [NUM_WORDS];
    logic [DATA_W-1:0]    ovr_q  [NUM_WORDS];
    logic [NUM_WORDS-1:0] ovr_vld_q;

    // behavioural fuse cells: cleared only by reset, bits only ever set
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) fuse_q[i] <= '0;
            ovr_vld_q <= '0;
        end else begin
            if (burn) fuse_q[burn_idx][burn_bit] <= 1'b1;
            if (sh_wr) ovr_vld_q[sh_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (sh_wr) ovr_q[sh_idx] <= sh_wdata;
    end

    assign sense_word = fuse_q[sense_idx];
    assign sh_rdata   = ovr_vld_q[sh_idx] ? ovr_q[sh_idx] : fuse_q[sh_idx];

    // R3: a burn leaves the addressed cell set
    a_r3_burn_sticks: assert property (@(posedge clk) disable iff (rst)
        burn |=> fuse_q[$past(burn_idx)][$past(burn_bit)]);

endmodule

// File: rtl/efuse_seq.sv
module efuse_seq
    import efuse_pkg::*;
#(
    parameter int                   CYCLE_CLKS = 16,
    parameter logic [NUM_BANKS-1:0] WR_PROT    = 8'b0100_0000,
    parameter logic [NUM_BANKS-1:0] RD_PROT    = 8'b1000_0000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_prog,
    input  logic      start_sense,
    input  logic      key_ok,
    input  fuse_loc_t start_loc,
    output logic      busy,
    output op_e       op,
    output fuse_loc_t cur_loc,
    output logic      burn,
    output logic      prog_done_ev,
    output logic      sense_done_ev,
    output logic      wprot_ev,
    output logic      snse_ev
);

    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLE_CLKS - 1);

    op_e              op_q;
    logic [CNT_W-1:0] cnt_q;
    fuse_loc_t        loc_q;
    logic             prog_go, sense_go, last;

    assign busy    = (op_q != OP_IDLE);
    assign op      = op_q;
    assign cur_loc = loc_q;

    assign wprot_ev = start_prog && !busy && (!key_ok || WR_PROT[start_loc.bank]);
    assign prog_go  = start_prog && !busy && !wprot_ev;
    assign snse_ev  = start_sense && !start_prog && !busy && RD_PROT[start_loc.bank];
    assign sense_go = start_sense && !start_prog && !busy && !RD_PROT[start_loc.bank];

    assign last          = busy && (cnt_q == '0);
    assign burn          = last && (op_q == OP_PROG);
    assign prog_done_ev  = burn;
    assign sense_done_ev = last && (op_q == OP_SENSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_IDLE;
            cnt_q <= '0;
            loc_q <= '0;
        end else if (prog_go || sense_go) begin
            op_q  <= prog_go ? OP_PROG : OP_SENSE;
            cnt_q <= CNT_LAST;
            loc_q <= start_loc;
        end else if (last) begin
            op_q <= OP_IDLE;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // independent run-length counter used by the cycle-length check
    logic [CNT_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst || !busy) run_q <= '0;
        else              run_q <= run_q + 1'b1;
    end

    // R6: busy lasts exactly CYCLE_CLKS clocks
    a_r6_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(run_q) == CNT_LAST));

    // R4: a refused program start never raises busy
    a_r4_reject_idle: assert property (@(posedge clk) disable iff (rst)
        (wprot_ev && !busy) |=> !busy);

    // R8: a refused sense start never raises busy
    a_r8_sense_reject: assert property (@(posedge clk) disable iff (rst)
        (snse_ev && !busy) |=> !busy);

endmodule

// File: rtl/efuse_ctrl.sv
module efuse_ctrl
    import efuse_pkg::*;
#(
    parameter int                   CYCLE_CLKS = 16,
    parameter logic [NUM_BANKS-1:0] RD_PROT    = 8'b1000_0000,
    parameter logic [NUM_BANKS-1:0] WR_PROT    = 8'b0100_0000,
    parameter logic [NUM_BANKS-1:0] OVR_PROT   = 8'b0010_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    logic [1:0] stat_q;      // {prog done, sense done}
    logic [1:0] statm_q;
    logic [7:0] err_q;
    logic [7:0] emask_q;
    logic [7:0] cfg_q;
    logic [5:0] ahi_q;
    logic [7:0] alo_q;
    logic [7:0] sdat_q;
    logic [7:0] key_q;

    logic              is_sh;
    logic [IDX_W-1:0]  sh_idx;
    logic [BANK_W-1:0] sh_bank;
    assign is_sh   = reg_addr[REG_AW-1];
    assign sh_idx  = reg_addr[IDX_W-1:0];
    assign sh_bank = sh_idx[IDX_W-1 -: BANK_W];

    function automatic logic reg_hit(input logic [REG_AW-1:0] a, input int off);
        return !a[REG_AW-1] && (a[IDX_W-1:0] == IDX_W'(off));
    endfunction

    logic wr_ctrl, start_prog, start_sense;
    assign wr_ctrl     = reg_wr && reg_hit(reg_addr, RA_CTRL);
    assign start_prog  = wr_ctrl && reg_wdata[FC_PRG];
    assign start_sense = wr_ctrl && reg_wdata[FC_SNS];

    fuse_loc_t start_loc, cur_loc;
    assign start_loc = decode_loc({2'b00, ahi_q}, alo_q);

    logic busy, burn, prog_done_ev, sense_done_ev, wprot_ev, snse_ev;
    op_e  op;

    efuse_seq #(
        .CYCLE_CLKS (CYCLE_CLKS),
        .WR_PROT    (WR_PROT),
        .RD_PROT    (RD_PROT)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_prog    (start_prog),
        .start_sense   (start_sense),
        .key_ok        (key_q == PROG_KEY),
        .start_loc     (start_loc),
        .busy          (busy),
        .op            (op),
        .cur_loc       (cur_loc),
        .burn          (burn),
        .prog_done_ev  (prog_done_ev),
        .sense_done_ev (sense_done_ev),
        .wprot_ev      (wprot_ev),
        .snse_ev       (snse_ev)
    );

    logic              sh_wr, ope_ev, rpe_ev;
    logic [DATA_W-1:0] sense_word, sh_rdata;
    assign ope_ev = reg_wr && is_sh && OVR_PROT[sh_bank];
    assign sh_wr  = reg_wr && is_sh && !OVR_PROT[sh_bank];
    assign rpe_ev = reg_rd && is_sh && RD_PROT[sh_bank];

    efuse_array u_array (
        .clk        (clk),
        .rst        (rst),
        .burn       (burn),
        .burn_idx   (loc_index(cur_loc)),
        .burn_bit   (cur_loc.bitn),
        .sense_idx  (loc_index(cur_loc)),
        .sense_word (sense_word),
        .sh_idx     (sh_idx),
        .sh_wr      (sh_wr),
        .sh_wdata   (reg_wdata[DATA_W-1:0]),
        .sh_rdata   (sh_rdata)
    );

    logic [7:0] err_set;
    always_comb begin
        err_set = '0;
        err_set[ER_WPROT] = wprot_ev;
        err_set[ER_SENSE] = snse_ev;
        err_set[ER_OPROT] = ope_ev;
        err_set[ER_RPROT] = rpe_ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            statm_q <= '0;
            err_q   <= '0;
            emask_q <= '0;
            cfg_q   <= '0;
            ahi_q   <= '0;
            alo_q   <= '0;
            sdat_q  <= '0;
            key_q   <= '0;
        end else begin
            if (reg_wr && !is_sh) begin
                if (reg_hit(reg_addr, RA_STAT)) begin
                    stat_q <= stat_q & ~{reg_wdata[ST_PRGD], reg_wdata[ST_SNSD]};
                end
                if (reg_hit(reg_addr, RA_ERR))   err_q   <= err_q & ~reg_wdata[7:0];
                if (reg_hit(reg_addr, RA_STATM)) statm_q <= reg_wdata[1:0];
                if (reg_hit(reg_addr, RA_EMASK)) emask_q <= reg_wdata[7:0] & ER_IMPL;
                if (reg_hit(reg_addr, RA_KEY))   key_q   <= reg_wdata[7:0];
                if (!busy) begin
                    if (reg_hit(reg_addr, RA_CTRL)) cfg_q <= reg_wdata[7:0] & FC_CFG_MASK;
                    if (reg_hit(reg_addr, RA_AHI))  ahi_q <= reg_wdata[5:0];
                    if (reg_hit(reg_addr, RA_ALO))  alo_q <= reg_wdata[7:0];
                end
            end
            // event setting wins over a same-cycle clear
            if (prog_done_ev)  stat_q[1] <= 1'b1;
            if (sense_done_ev) begin
                stat_q[0] <= 1'b1;
                sdat_q    <= sense_word;
            end
            if (|err_set) err_q <= (err_q & ~(reg_wr && reg_hit(reg_addr, RA_ERR) ? reg_wdata[7:0] : 8'h00))
                                   | err_set;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (is_sh) begin
            reg_rdata[DATA_W-1:0] = RD_PROT[sh_bank] ? '0 : sh_rdata;
        end else begin
            unique case (reg_addr[IDX_W-1:0])
                IDX_W'(RA_STAT):  begin
                    reg_rdata[ST_BUSY] = busy;
                    reg_rdata[ST_PRGD] = stat_q[1];
                    reg_rdata[ST_SNSD] = stat_q[0];
                end
                IDX_W'(RA_ERR):   reg_rdata[7:0] = err_q;
                IDX_W'(RA_STATM): reg_rdata[1:0] = statm_q;
                IDX_W'(RA_EMASK): reg_rdata[7:0] = emask_q;
                IDX_W'(RA_CTRL):  begin
                    reg_rdata[7:0]  = cfg_q;
                    reg_rdata[FC_PRG] = (op == OP_PROG);
                    reg_rdata[FC_SNS] = (op == OP_SENSE);
                end
                IDX_W'(RA_AHI):   reg_rdata[5:0] = ahi_q;
                IDX_W'(RA_ALO):   reg_rdata[7:0] = alo_q;
                IDX_W'(RA_SDATA): reg_rdata[7:0] = sdat_q;
                IDX_W'(RA_KEY):   reg_rdata[7:0] = key_q;
                default:          reg_rdata = '0;
            endcase
        end
    end

    assign irq = |(stat_q & statm_q) | |(err_q & emask_q);

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[31:8]};

    // R7: a finished sense leaves sense-done set
    a_r7_sense_done: assert property (@(posedge clk) disable iff (rst)
        sense_done_ev |=> stat_q[0]);

    // R10: a refused override is flagged
    a_r10_ovr_err: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && is_sh && OVR_PROT[sh_bank]) |=> err_q[ER_OPROT]);

    // R11: a protected shadow read is flagged
    a_r11_rprot_err: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && is_sh && RD_PROT[sh_bank]) |=> err_q[ER_RPROT]);

    // R12: status bits never appear while neither cycle finished nor they were set
    a_r12_prgd_source: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[1]) |-> $past(busy));

endmodule

// File: tb/sim_efuse_ctrl.sv
module sim_efuse_ctrl;
    import efuse_pkg::*;

    localparam int CYC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #4 clk = ~clk;

    efuse_ctrl #(.CYCLE_CLKS(CYC)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] fm [2048];
    logic [7:0] om [2048];
    logic       ov [2048];

    function automatic logic [11:0] sh_addr(input int bank, input int word);
        return 12'h800 | 12'(bank * 256 + word);
    endfunction

    function automatic logic [7:0] exp_shadow(input int bank, input int word);
        if (bank == 7) return 8'h00;
        return ov[bank*256+word] ? om[bank*256+word] : fm[bank*256+word];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    // run one cycle; returns status, error, control read in first cycle, busy length
    task automatic run_cycle(input int bank, input int word, input int bitn,
                             input logic [7:0] key, input logic [7:0] ctl,
                             output logic [31:0] st, output logic [31:0] er,
                             output logic [31:0] ctl_in, output int blen);
        logic [31:0] d;
        wr(12'(RA_STAT), 32'h3);
        wr(12'(RA_ERR), 32'hFF);
        wr(12'(RA_KEY), {24'h0, key});
        wr(12'(RA_AHI), 32'(bank << 3 | (word >> 5)));
        wr(12'(RA_ALO), 32'(((word & 31) << 3) | bitn));
        wr(12'(RA_CTRL), {24'h0, ctl});
        rd(12'(RA_CTRL), ctl_in);
        blen = (ctl_in[0] | ctl_in[3]) ? 1 : 0;
        for (int k = 0; k < 1000; k++) begin
            rd(12'(RA_STAT), d);
            if (!d[7]) break;
            blen++;
        end
        rd(12'(RA_STAT), st);
        rd(12'(RA_ERR), er);
        wr(12'(RA_KEY), 32'h0);
    endtask

    task automatic do_prog(input string req, input int bank, input int word, input int bitn,
                           input logic [7:0] key);
        logic [31:0] st, er, ci;
        int bl;
        logic ok;
        ok = (key == 8'hAA) && (bank != 6);
        run_cycle(bank, word, bitn, key, 8'h01, st, er, ci, bl);
        if (ok) fm[bank*256+word][bitn] = 1'b1;
        chk({req, " status"}, st, ok ? 32'h2 : 32'h0);
        chk({req, " error"}, er, ok ? 32'h0 : 32'h40);
        chk({req, " busy length"}, 32'(bl), ok ? 32'(CYC) : 32'h0);
    endtask

    task automatic do_sense(input string req, input int bank, input int word,
                            input logic [7:0] prev_sd);
        logic [31:0] st, er, ci, sd;
        int bl;
        run_cycle(bank, word, 0, 8'h00, 8'h08, st, er, ci, bl);
        rd(12'(RA_SDATA), sd);
        if (bank == 7) begin
            chk({req, " sense refused status"}, st, 32'h0);
            chk({req, " sense refused error"}, er, 32'h04);
            chk({req, " sense data kept"}, sd, {24'h0, prev_sd});
        end else begin
            chk({req, " sense status"}, st, 32'h1);
            chk({req, " sense data"}, sd, {24'h0, fm[bank*256+word]});
            chk({req, " sense busy length"}, 32'(bl), 32'(CYC));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, st, er, ci;
        logic [7:0]  last_sd;
        int bl;
        for (int i = 0; i < 2048; i++) begin fm[i] = 0; om[i] = 0; ov[i] = 0; end
        void'($urandom(32'd20240611));

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values
        for (int a = 0; a < 9; a++) begin
            rd(12'(a), d);
            chk("R1 register reset", d, 32'h0);
        end
        chk("R1 irq reset", 32'(irq), 32'h0);

        // R6: control bit visible during program, clear afterwards
        run_cycle(0, 8'h25, 3, 8'hAA, 8'h01, st, er, ci, bl);
        fm[8'h25][3] = 1'b1;
        chk("R6 program start bit during cycle", 32'(ci[0]), 32'h1);
        chk("R6 busy length", 32'(bl), 32'(CYC));
        rd(12'(RA_CTRL), d);
        chk("R6 start bit cleared", d & 32'h9, 32'h0);
        chk("R3 program done", st, 32'h2);

        // R2: address decode observed through shadow read of a distinct word
        do_prog("R2 decode", 3, 8'hE7, 6, 8'hAA);
        rd(sh_addr(3, 8'hE7), d);
        chk("R2 shadow shows decoded bit", d, 32'h40);
        rd(sh_addr(3, 8'hE6), d);
        chk("R2 neighbour untouched", d, {24'h0, exp_shadow(3, 8'hE6)});

        // R7: sense of a burned word
        do_sense("R7", 0, 8'h25, 8'h00);
        last_sd = fm[8'h25];

        // R4: wrong key
        do_prog("R4 no key", 1, 8'h10, 0, 8'h55);
        rd(sh_addr(1, 8'h10), d);
        chk("R4 array unchanged", d, {24'h0, exp_shadow(1, 8'h10)});

        // R5: write-protected bank
        do_prog("R5 protected bank", 6, 8'h33, 2, 8'hAA);
        rd(sh_addr(6, 8'h33), d);
        chk("R5 array unchanged", d, 32'h0);

        // R8: read-protected sense
        do_sense("R8", 7, 8'h01, last_sd);

        // R9: override hides fuse in shadow but not in sense
        wr(sh_addr(0, 8'h25), 32'h5A);
        om[8'h25] = 8'h5A; ov[8'h25] = 1'b1;
        rd(sh_addr(0, 8'h25), d);
        chk("R9 override readback", d, 32'h5A);
        do_sense("R9", 0, 8'h25, 8'h00);

        // R10: override-protected bank
        wr(12'(RA_ERR), 32'hFF);
        wr(sh_addr(5, 8'h11), 32'hC3);
        rd(12'(RA_ERR), d);
        chk("R10 override error", d, 32'h20);
        rd(sh_addr(5, 8'h11), d);
        chk("R10 value not stored", d, 32'h0);

        // R11: read-protected shadow read
        wr(12'(RA_ERR), 32'hFF);
        rd(sh_addr(7, 8'h02), d);
        chk("R11 data zero", d, 32'h0);
        rd(12'(RA_ERR), d);
        chk("R11 read-protect error", d, 32'h10);

        // R12: write-1-to-clear behaviour
        do_prog("R12 setup", 2, 8'h40, 1, 8'hAA);
        wr(12'(RA_STAT), 32'h80);
        rd(12'(RA_STAT), d);
        chk("R12 busy not writable, done kept", d, 32'h2);
        wr(12'(RA_STAT), 32'h2);
        rd(12'(RA_STAT), d);
        chk("R12 done cleared", d, 32'h0);
        do_prog("R12 err setup", 2, 8'h41, 1, 8'h00);
        wr(12'(RA_ERR), 32'h20);
        rd(12'(RA_ERR), d);
        chk("R12 other err bit write keeps", d, 32'h40);
        wr(12'(RA_ERR), 32'h40);
        rd(12'(RA_ERR), d);
        chk("R12 err cleared", d, 32'h0);

        // R13: interrupt masking
        wr(12'(RA_STATM), 32'h2);
        do_prog("R13 setup", 4, 8'h05, 5, 8'hAA);
        chk("R13 irq on masked done", 32'(irq), 32'h1);
        wr(12'(RA_STAT), 32'h3);
        chk("R13 irq cleared", 32'(irq), 32'h0);
        wr(12'(RA_EMASK), 32'h40);
        do_prog("R13 err setup", 4, 8'h06, 5, 8'h12);
        chk("R13 irq on masked error", 32'(irq), 32'h1);
        wr(12'(RA_ERR), 32'hFF);
        chk("R13 irq error cleared", 32'(irq), 32'h0);
        wr(12'(RA_STATM), 32'h0);
        wr(12'(RA_EMASK), 32'h0);

        // R3 / R9: random programs, senses and overrides
        for (int it = 0; it < 30; it++) begin
            int b, w, bt;
            b  = $urandom_range(0, 4);
            w  = $urandom_range(0, 255);
            bt = $urandom_range(0, 7);
            do_prog("R3 random", b, w, bt, ($urandom_range(0, 3) == 0) ? 8'h3C : 8'hAA);
            rd(sh_addr(b, w), d);
            chk("R9 random shadow", d, {24'h0, exp_shadow(b, w)});
            if ($urandom_range(0, 2) == 0) begin
                logic [7:0] v;
                v = 8'($urandom());
                wr(sh_addr(b, w), {24'h0, v});
                if (b != 5) begin om[b*256+w] = v; ov[b*256+w] = 1'b1; end
                rd(sh_addr(b, w), d);
                chk("R9 random override", d, {24'h0, exp_shadow(b, w)});
            end
            if ($urandom_range(0, 1) == 0) do_sense("R7 random", b, w, 8'h00);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule